// File: doc/BRIEF.md
# Signed Double-Width Integer Divider

A sequential signed divider for a processor datapath. A double-width dividend is divided by a single-width divisor. The block returns a quotient and a remainder packed into one double-width result word. One input selects between two sizes. In word mode a 32-bit dividend is divided by a 16-bit divisor. In byte mode a 16-bit dividend is divided by an 8-bit divisor.

Division truncates toward zero, so a nonzero remainder takes the sign of the dividend. An overflow flag reports two cases: a zero divisor, and a signed quotient too large for the single-width field. In either case the packed result carries no meaning.

The core runs a restoring shift-subtract loop on operand magnitudes and produces one quotient bit per clock. The sequence is one setup cycle, then 8 or 16 iteration cycles, then one sign-correction cycle. Two cases finish straight after setup, with no iteration: a zero divisor, and a dividend whose upper-half magnitude is already at least the divisor magnitude.

Top module: `sdiv_top`

## Requirements
- R1: Word mode (`word_mode`=1): `dividend[31:0]` and `divisor[15:0]` are signed. When no overflow occurs, `result[15:0]` holds the quotient truncated toward zero and `result[31:16]` holds the remainder.
- R2: Byte mode (`word_mode`=0): only `dividend[15:0]` and `divisor[7:0]` are used, both signed. The other input bits are ignored. When no overflow occurs, `result[7:0]` holds the quotient, `result[15:8]` holds the remainder and `result[31:16]` is zero.
- R3: A nonzero remainder has the sign of the dividend. Its magnitude is less than the divisor magnitude.
- R4: A zero divisor sets `ovf` together with `done`, one clock edge after the edge that samples `start`.
- R5: `ovf` is set when the true quotient lies outside the signed field range. For an n-bit field (n = 8 or 16) that range is -2^(n-1) to 2^(n-1)-1.
- R6: `ovf` is cleared by every division that finishes with neither overflow nor a zero divisor.
- R7: Latency is counted from the edge that samples `start`. If the divisor is zero, or |dividend| >= |divisor|·2^n, `done` rises after 1 edge. Otherwise it rises after n+2 edges.
- R8: `done` is high for exactly one cycle. `result` and `ovf` then hold their values until the next accepted start.
- R9: A `start` that arrives while a division is in progress is ignored. The running division still returns its own result.
- R10: After reset, `done`, `ovf` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division with the current operands (accepted only when idle) |
| word_mode | input | 1 | 1 = 32/16 word division, 0 = 16/8 byte division |
| dividend | input | 32 | Signed dividend (byte mode uses bits 15:0) |
| divisor | input | 16 | Signed divisor (byte mode uses bits 7:0) |
| result | output | 32 | Packed remainder and quotient |
| ovf | output | 1 | Quotient overflow or divide by zero |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties assume that operands stay stable only in the cycle where `start` is sampled. After that, the block works solely from its latched copies. The stable-output property also assumes that `start` is the only way to leave idle. The stimulus changes the operand pins freely while a division is in progress, and it raises `start` again mid-division to exercise R9. Every division waits for its `done` pulse and one further idle cycle before the next start is issued. Operand cases include the most negative dividend, a divisor of -1, a zero dividend, a zero divisor and the exact signed quotient limits in both modes, plus randomized operands.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SETUP = 2'd1,
        S_ITER  = 2'd2,
        S_FIX   = 2'd3
    } sdiv_state_e;
endpackage

// File: rtl/sdiv_operand_prep.sv
// Sign-extends the operands for the selected size, takes magnitudes and
// aligns them for the shift-subtract loop. Also detects early termination.
module sdiv_operand_prep #(
    parameter int W = 16
) (
    input  logic             word_mode,
    input  logic [2*W-1:0]   dvd_raw,
    input  logic [W-1:0]     dvs_raw,
    output logic [W:0]       rem_init,
    output logic [W-1:0]     low_init,
    output logic [W-1:0]     dvs_mag,
    output logic             neg_q,
    output logic             neg_r,
    output logic             div_zero,
    output logic             quot_big
);
    localparam int H = W / 2;

    logic [2*W-1:0] dvd_ext;
    logic [W-1:0]   dvs_ext;
    logic [2*W-1:0] dvd_mag;

    always_comb begin
        if (word_mode) begin
            dvd_ext = dvd_raw;
            dvs_ext = dvs_raw;
        end else begin
            dvd_ext = {{W{dvd_raw[W-1]}}, dvd_raw[W-1:0]};
            dvs_ext = {{(W-H){dvs_raw[H-1]}}, dvs_raw[H-1:0]};
        end
        dvd_mag  = dvd_ext[2*W-1] ? ((2*W)'(0) - dvd_ext) : dvd_ext;
        dvs_mag  = dvs_ext[W-1]   ? (W'(0) - dvs_ext)     : dvs_ext;
        neg_r    = dvd_ext[2*W-1];
        neg_q    = dvd_ext[2*W-1] ^ dvs_ext[W-1];
        div_zero = (dvs_ext == '0);
        if (word_mode) begin
            rem_init = {1'b0, dvd_mag[2*W-1:W]};
            low_init = dvd_mag[W-1:0];
        end else begin
            rem_init = {{(W-H+1){1'b0}}, dvd_mag[W-1:H]};
            low_init = {dvd_mag[H-1:0], {(W-H){1'b0}}};
        end
        quot_big = (rem_init >= {1'b0, dvs_mag});
    end
endmodule

// File: rtl/sdiv_result_fix.sv
// Applies signs to the magnitude results, checks the signed quotient range
// and packs remainder and quotient for the selected size.
module sdiv_result_fix #(
    parameter int W = 16
) (
    input  logic             word_mode,
    input  logic [W-1:0]     q_mag,
    input  logic [W-1:0]     r_mag,
    input  logic             neg_q,
    input  logic             neg_r,
    output logic [2*W-1:0]   packed_res,
    output logic             range_ovf
);
    localparam int H = W / 2;

    logic [W-1:0] lim_pos;
    logic [W-1:0] lim;
    logic [W-1:0] q_s;
    logic [W-1:0] r_s;

    always_comb begin
        lim_pos   = word_mode ? {1'b0, {(W-1){1'b1}}}
                              : {{(W-H+1){1'b0}}, {(H-1){1'b1}}};
        lim       = lim_pos + W'(neg_q);
        range_ovf = (q_mag > lim);
        q_s       = neg_q ? (W'(0) - q_mag) : q_mag;
        r_s       = neg_r ? (W'(0) - r_mag) : r_mag;
        if (word_mode) packed_res = {r_s, q_s};
        else           packed_res = {{W{1'b0}}, r_s[H-1:0], q_s[H-1:0]};
    end
endmodule

// File: rtl/sdiv_top.sv
module sdiv_top
    import sdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             word_mode,
    input  logic [2*W-1:0]   dividend,
    input  logic [W-1:0]     divisor,
    output logic [2*W-1:0]   result,
    output logic             ovf,
    output logic             done
);
    localparam int H  = W / 2;
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        sdiv_state_e     state;
        logic            mode;
        logic [2*W-1:0]  dvd;
        logic [W-1:0]    dvs;
        logic [W:0]      rem;
        logic [W-1:0]    low;
        logic [CW-1:0]   cnt;
        logic            neg_q;
        logic            neg_r;
        logic [2*W-1:0]  res;
        logic            ovf;
        logic            done;
    } sdiv_regs_t;

    sdiv_regs_t s_d, s_q;

    logic [W:0]     p_rem_init;
    logic [W-1:0]   p_low_init;
    logic [W-1:0]   p_dvs_mag;
    logic           p_neg_q, p_neg_r, p_div_zero, p_quot_big;
    logic [2*W-1:0] f_res;
    logic           f_ovf;
    logic [W:0]     trial;
    logic           qbit;

    sdiv_operand_prep #(.W(W)) u_prep (
        .word_mode (s_q.mode),
        .dvd_raw   (s_q.dvd),
        .dvs_raw   (s_q.dvs),
        .rem_init  (p_rem_init),
        .low_init  (p_low_init),
        .dvs_mag   (p_dvs_mag),
        .neg_q     (p_neg_q),
        .neg_r     (p_neg_r),
        .div_zero  (p_div_zero),
        .quot_big  (p_quot_big)
    );

    sdiv_result_fix #(.W(W)) u_fix (
        .word_mode  (s_q.mode),
        .q_mag      (s_q.low),
        .r_mag      (s_q.rem[W-1:0]),
        .neg_q      (s_q.neg_q),
        .neg_r      (s_q.neg_r),
        .packed_res (f_res),
        .range_ovf  (f_ovf)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        trial    = {s_q.rem[W-1:0], s_q.low[W-1]};
        qbit     = (trial >= {1'b0, s_q.dvs});
        case (s_q.state)
            S_IDLE: begin
                if (start) begin
                    s_d.mode  = word_mode;
                    s_d.dvd   = dividend;
                    s_d.dvs   = divisor;
                    s_d.state = S_SETUP;
                end
            end
            S_SETUP: begin
                s_d.neg_q = p_neg_q;
                s_d.neg_r = p_neg_r;
                if (p_div_zero || p_quot_big) begin
                    s_d.ovf   = 1'b1;
                    s_d.done  = 1'b1;
                    s_d.state = S_IDLE;
                end else begin
                    s_d.rem   = p_rem_init;
                    s_d.low   = p_low_init;
                    s_d.dvs   = p_dvs_mag;
                    s_d.cnt   = s_q.mode ? CW'(W) : CW'(H);
                    s_d.state = S_ITER;
                end
            end
            S_ITER: begin
                s_d.rem = qbit ? (trial - {1'b0, s_q.dvs}) : trial;
                s_d.low = {s_q.low[W-2:0], qbit};
                s_d.cnt = s_q.cnt - CW'(1);
                if (s_q.cnt == CW'(1)) s_d.state = S_FIX;
            end
            S_FIX: begin
                s_d.res   = f_res;
                s_d.ovf   = f_ovf;
                s_d.done  = 1'b1;
                s_d.state = S_IDLE;
            end
            default: s_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= S_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign result = s_q.res;
    assign ovf    = s_q.ovf;
    assign done   = s_q.done;

    // Partial remainder never reaches the divisor magnitude while iterating (R3)
    assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == S_ITER) |-> (s_q.rem < {1'b0, s_q.dvs}));

    // Zero divisor finishes straight after setup with the flag set (R4)
    assert_zero_divisor_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == S_SETUP && p_div_zero) |=> (done && ovf));

    // Completion only ever follows setup or sign correction (R7)
    assert_done_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(s_q.state) == S_SETUP || $past(s_q.state) == S_FIX));

    // Completion is a single-cycle pulse (R8)
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Outputs hold while idle without a new start (R8)
    assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == S_IDLE && !start) |=> ($stable(result) && $stable(ovf)));

    // A division in progress keeps its latched size mode (R9)
    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state != S_IDLE) |=> $stable(s_q.mode));
endmodule

// File: tb/sdiv_top_test.sv
`timescale 1ns/1ps
module sdiv_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        word_mode = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic [31:0] result;
    logic        ovf;
    logic        done;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sdiv_top #(.W(16)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .word_mode(word_mode),
        .dividend(dividend), .divisor(divisor),
        .result(result), .ovf(ovf), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic longint labs(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic run_case(input bit wm, input logic [31:0] dvd, input logic [15:0] dvs, input bit poke);
        longint a, b, qe, re, lim;
        int n, lat, seen_at;
        bit eovf;
        logic [31:0] exp_res, held_res;
        logic held_ovf;
        string tag;
        n  = wm ? 16 : 8;
        qe = 0;
        re = 0;
        if (wm) begin
            a = longint'($signed(dvd));
            b = longint'($signed(dvs));
        end else begin
            a = longint'($signed(dvd[15:0]));
            b = longint'($signed(dvs[7:0]));
        end
        lim = longint'(1) << (n - 1);
        if (b == 0) begin
            eovf = 1'b1;
            lat  = 1;
        end else begin
            qe   = a / b;
            re   = a % b;
            eovf = (qe > lim - 1) || (qe < -lim);
            lat  = (labs(a) >= (labs(b) << n)) ? 1 : n + 2;
        end
        if (wm) exp_res = {re[15:0], qe[15:0]};
        else    exp_res = {16'h0000, re[7:0], qe[7:0]};

        @(negedge clk);
        start = 1'b1; word_mode = wm; dividend = dvd; divisor = dvs;
        @(negedge clk);
        start = 1'b0; dividend = 32'hDEAD_BEEF; divisor = 16'h0000; word_mode = ~wm;
        seen_at = -1;
        held_res = '0;
        held_ovf = 1'b0;
        for (int k = 1; k <= lat + 1; k++) begin
            @(negedge clk);
            if (done && seen_at < 0) seen_at = k;
            if (k == 1 && poke && lat > 2) begin
                start = 1'b1; dividend = 32'h0000_0001; divisor = 16'h0001;
            end
            if (k == 2) start = 1'b0;
            if (k == lat) begin
                if (b == 0) tag = "R4 zero divisor ovf";
                else if (eovf) tag = "R5 range ovf";
                else tag = "R6 ovf clear";
                chk(ovf == eovf, tag, 64'(ovf), 64'(eovf));
                if (!eovf) begin
                    if (wm) tag = (a < 0) ? "R1/R3 word result" : "R1 word result";
                    else    tag = (a < 0) ? "R2/R3 byte result" : "R2 byte result";
                    if (poke) tag = {tag, " R9 busy start ignored"};
                    chk(result == exp_res, tag, 64'(result), 64'(exp_res));
                end
                held_res = result;
                held_ovf = ovf;
            end
            if (k == lat + 1) begin
                chk(!done, "R8 done single pulse", 64'(done), 64'(0));
                chk(result == held_res && ovf == held_ovf, "R8 outputs held",
                    {31'h0, ovf, result}, {31'h0, held_ovf, held_res});
            end
        end
        chk(seen_at == lat, (lat == 1) ? "R7/R4 early latency" : "R7 latency",
            64'(seen_at), 64'(lat));
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && ovf == 1'b0 && result == '0, "R10 reset state",
            {31'h0, ovf, result}, 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // word mode
        run_case(1'b1, 32'd100, 16'd7, 1'b0);
        run_case(1'b1, -32'sd100, 16'd7, 1'b1);
        run_case(1'b1, 32'd100, -16'sd7, 1'b0);
        run_case(1'b1, -32'sd100, -16'sd7, 1'b0);
        run_case(1'b1, 32'd0, 16'd5, 1'b0);
        run_case(1'b1, 32'h8000_0000, 16'hFFFF, 1'b0);
        run_case(1'b1, 32'd32767, 16'hFFFF, 1'b0);
        run_case(1'b1, -32'sd65536, 16'd2, 1'b0);
        run_case(1'b1, 32'd65536, 16'd2, 1'b0);
        run_case(1'b1, 32'd123456, 16'd0, 1'b0);
        run_case(1'b1, 32'd65535, 16'd2, 1'b0);
        run_case(1'b1, 32'hFFFF_8000, 16'hFFFF, 1'b0);
        // byte mode
        run_case(1'b0, 32'hABCD_FF9C, 16'hFF07, 1'b1);
        run_case(1'b0, 32'h0000_0064, 16'h00F9, 1'b0);
        run_case(1'b0, 32'h0000_0000, 16'h0005, 1'b0);
        run_case(1'b0, 32'h0000_8000, 16'h00FF, 1'b0);
        run_case(1'b0, 32'h0000_007F, 16'h00FF, 1'b0);
        run_case(1'b0, 32'h0000_FF00, 16'h0002, 1'b0);
        run_case(1'b0, 32'h0000_0100, 16'h0002, 1'b0);
        run_case(1'b0, 32'h0000_1234, 16'h1200, 1'b0);
        run_case(1'b0, 32'h0000_00FE, 16'h0002, 1'b0);
        run_case(1'b1, 32'd50, 16'd7, 1'b0);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] rd;
            logic [15:0] rs;
            bit rm;
            rm = $urandom_range(0, 1) == 1;
            rd = $urandom;
            rs = 16'($urandom);
            if (i % 2 == 0) rd = {{12{rd[19]}}, rd[19:0]};
            if (i % 3 == 0) rs = {{8{rs[7]}}, rs[7:0]};
            run_case(rm, rd, rs, (i % 5) == 0);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule